// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Per-Pin Interrupt Detection

The block is a memory-mapped controller for eight general-purpose pins. Software reaches it through a simple register bus with byte-wide data. Each pin has a direction bit and a stored output value. Each pin's input is brought into the clock domain through a two-flop synchronizer.

Access to pin data uses the address as a per-pin mask. Address bit (n+2) selects pin n, so software can change or sample any subset of pins without a read-modify-write sequence.

Each pin also has its own interrupt detector. The detector can fire on a rising edge, a falling edge, both edges, a high level or a low level. Edge events stay latched until software clears them. Level events follow the live input. The per-pin status is gated by an enable mask, and the enabled bits are ORed into one interrupt line.

The bus is combinational on reads: `regRdData` is valid in the same cycle as a read access. Writes take effect at the next rising clock edge. Only word-aligned addresses (bits [1:0] equal to 0) hit a register. Any other access reads 0 and writes nothing.

Top module: `gpio8_irq`

## Requirements
- R1: Reset has these effects.
  - Every pin becomes an input (`pinOutEn` = 0).
  - The output value register is driven to 0 (`pinOut` = 0).
  - All interrupt configuration, enable and status bits are cleared, so `irqOut` is 0.
- R2: A write with address bits [11:10] = 0 is a data write. It updates only the output value bits selected by address bits [9:2], taking them from the write data. All other bits keep their value. Offset 0x3FC selects all eight pins.
- R3: A read with address bits [11:10] = 0 is a data read. It returns 0 for every pin not selected by address bits [9:2]. For a selected pin, it returns the stored output value if the pin is an output, and the synchronized input level if it is an input.
- R4: The direction register at 0x400 is read/write. A 1 in bit n makes pin n an output, and `pinOutEn` equals this register.
- R5: In edge mode with single-edge selection, a pin latches its raw status as follows.
  - Edge mode means sense bit = 0 (register at 0x404).
  - Single-edge selection means both-edges bit = 0 (register at 0x408).
  - With polarity bit = 1 (register at 0x40C) the pin latches on a rising edge. With polarity bit = 0 it latches on a falling edge.
  - The opposite edge neither sets nor clears the latched status.
- R6: In edge mode, a both-edges bit of 1 latches status on either edge and ignores the polarity bit.
- R7: In level mode (sense bit = 1), raw status follows the live synchronized input. It tracks a high level when the polarity bit is 1 and a low level when the polarity bit is 0. Writing the clear register does not change it.
- R8: The clear register at 0x41C works as follows.
  - Writing a 1 to bit n clears pin n's latched edge status.
  - Writing a 0 leaves the status unchanged.
  - An edge arriving in the same cycle as a clear wins, so the status stays set.
- R9: Raw status is readable at 0x414. Masked status, equal to raw AND the enable mask at 0x410, is readable at 0x418. `irqOut` is 1 exactly when the masked status is non-zero.
- R10: The register at 0x420 is plain read/write storage. Writing it changes no pin output and no interrupt status.
- R11: A change on `pinIn` first appears in a data read two rising clock edges later. It is not visible after only one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access strobe |
| regWrEn | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational |
| pinIn | input | 8 | Pin input levels |
| pinOut | output | 8 | Pin output values |
| pinOutEn | output | 8 | Pin output enables |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench sweeps all 256 address masks on data writes and data reads against an arithmetic model of the output register and the pin mix.

A wrong mask decode would corrupt unselected pins on writes, or leak their values into reads. A read path that ignored direction would return the pin input instead of the driven value.

Every pin is run through all five detection modes. A detector with swapped polarity, a non-sticky edge latch, or a level latch that could be cleared would each fail one of the per-step status reads.

Two timing cases are also targeted:
- A clear that coincides with a new edge. A design that gives the clear priority would lose the event.
- The synchronizer latency. A missing stage would expose a new input one edge early.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PIN_COUNT = 8;
  localparam int ADDR_W    = 12;
  localparam int WORD_W    = ADDR_W - 2;

  // Word indices (byte offset >> 2) of the configuration registers.
  localparam logic [WORD_W-1:0] W_DIR    = 10'h100;
  localparam logic [WORD_W-1:0] W_SENSE  = 10'h101;
  localparam logic [WORD_W-1:0] W_BOTH   = 10'h102;
  localparam logic [WORD_W-1:0] W_EVENT  = 10'h103;
  localparam logic [WORD_W-1:0] W_MASK   = 10'h104;
  localparam logic [WORD_W-1:0] W_RAW    = 10'h105;
  localparam logic [WORD_W-1:0] W_MASKED = 10'h106;
  localparam logic [WORD_W-1:0] W_CLEAR  = 10'h107;
  localparam logic [WORD_W-1:0] W_MODE   = 10'h108;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH,
    RD_EVENT, RD_MASK, RD_RAW, RD_MASKED, RD_MODE
  } rdSel_e;

  typedef struct packed {
    logic [PIN_COUNT-1:0] dataMask;
    logic wrData;
    logic wrDir;
    logic wrSense;
    logic wrBoth;
    logic wrEvent;
    logic wrMask;
    logic wrClear;
    logic wrMode;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              inData;

  assign aligned = regSel && (regAddr[1:0] == 2'b00);
  assign word    = regAddr[ADDR_W-1:2];
  assign inData  = (word[WORD_W-1:PIN_COUNT] == '0);

  always_comb begin
    stb          = '0;
    stb.rdSel    = RD_NONE;
    stb.dataMask = word[PIN_COUNT-1:0];
    if (aligned && inData) begin
      if (regWrEn) stb.wrData = 1'b1;
      else         stb.rdSel  = RD_DATA;
    end else if (aligned) begin
      unique case (word)
        W_DIR:    if (regWrEn) stb.wrDir   = 1'b1; else stb.rdSel = RD_DIR;
        W_SENSE:  if (regWrEn) stb.wrSense = 1'b1; else stb.rdSel = RD_SENSE;
        W_BOTH:   if (regWrEn) stb.wrBoth  = 1'b1; else stb.rdSel = RD_BOTH;
        W_EVENT:  if (regWrEn) stb.wrEvent = 1'b1; else stb.rdSel = RD_EVENT;
        W_MASK:   if (regWrEn) stb.wrMask  = 1'b1; else stb.rdSel = RD_MASK;
        W_RAW:    if (!regWrEn) stb.rdSel = RD_RAW;
        W_MASKED: if (!regWrEn) stb.rdSel = RD_MASKED;
        W_CLEAR:  if (regWrEn) stb.wrClear = 1'b1;
        W_MODE:   if (regWrEn) stb.wrMode  = 1'b1; else stb.rdSel = RD_MODE;
        default:  stb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
  input  logic clk,
  input  logic rstN,
  input  logic level,
  input  logic prevLevel,
  input  logic senseLvl,
  input  logic bothEdge,
  input  logic eventHi,
  input  logic clrPulse,
  output logic rawBit
);
  logic rise;
  logic fall;
  logic edgeHit;
  logic edgeLatch;

  assign rise    = level & ~prevLevel;
  assign fall    = ~level & prevLevel;
  assign edgeHit = bothEdge ? (rise | fall) : (eventHi ? rise : fall);

  always_ff @(posedge clk) begin
    if (!rstN || senseLvl) edgeLatch <= 1'b0;
    else                   edgeLatch <= edgeHit | (edgeLatch & ~clrPulse);
  end

  assign rawBit = senseLvl ? (eventHi ? level : ~level) : edgeLatch;
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic                 irqOut,
  output logic [PIN_COUNT-1:0] rawStatus,
  output logic [PIN_COUNT-1:0] intMask,
  output logic [PIN_COUNT-1:0] senseCfg
);
  logic [PIN_COUNT-1:0] outVal, dirReg, bothCfg, eventCfg, modeReg;
  logic [PIN_COUNT-1:0] syncA, syncB, prevB;
  logic [PIN_COUNT-1:0] pinView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outVal   <= '0;
      dirReg   <= '0;
      senseCfg <= '0;
      bothCfg  <= '0;
      eventCfg <= '0;
      intMask  <= '0;
      modeReg  <= '0;
      syncA    <= '0;
      syncB    <= '0;
      prevB    <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
      if (stb.wrData)  outVal   <= (outVal & ~stb.dataMask) | (wrData & stb.dataMask);
      if (stb.wrDir)   dirReg   <= wrData;
      if (stb.wrSense) senseCfg <= wrData;
      if (stb.wrBoth)  bothCfg  <= wrData;
      if (stb.wrEvent) eventCfg <= wrData;
      if (stb.wrMask)  intMask  <= wrData;
      if (stb.wrMode)  modeReg  <= wrData;
    end
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    gpio_pin_irq u_det (
      .clk      (clk),
      .rstN     (rstN),
      .level    (syncB[i]),
      .prevLevel(prevB[i]),
      .senseLvl (senseCfg[i]),
      .bothEdge (bothCfg[i]),
      .eventHi  (eventCfg[i]),
      .clrPulse (stb.wrClear & wrData[i]),
      .rawBit   (rawStatus[i])
    );
  end

  assign pinView  = (dirReg & outVal) | (~dirReg & syncB);
  assign pinOut   = outVal;
  assign pinOutEn = dirReg;
  assign irqOut   = |(rawStatus & intMask);

  always_comb begin
    unique case (stb.rdSel)
      RD_DATA:   rdData = pinView & stb.dataMask;
      RD_DIR:    rdData = dirReg;
      RD_SENSE:  rdData = senseCfg;
      RD_BOTH:   rdData = bothCfg;
      RD_EVENT:  rdData = eventCfg;
      RD_MASK:   rdData = intMask;
      RD_RAW:    rdData = rawStatus;
      RD_MASKED: rdData = rawStatus & intMask;
      RD_MODE:   rdData = modeReg;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio8_irq.sv
module gpio8_irq
  import gpio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regSel,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [PIN_COUNT-1:0] regWrData,
  output logic [PIN_COUNT-1:0] regRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic                 irqOut
);
  strobe_t              stb;
  logic [PIN_COUNT-1:0] rawStatus;
  logic [PIN_COUNT-1:0] intMask;
  logic [PIN_COUNT-1:0] senseCfg;

  gpio_ctrl u_ctrl (
    .regSel (regSel),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .stb    (stb)
  );

  gpio_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .rawStatus(rawStatus),
    .intMask  (intMask),
    .senseCfg (senseCfg)
  );
endmodule

// File: rtl/gpio8_irq_checker.sv
module gpio8_irq_checker
  import gpio_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regSel,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [PIN_COUNT-1:0] regRdData,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOutEn,
  input logic                 irqOut,
  input logic [PIN_COUNT-1:0] rawStatus,
  input logic [PIN_COUNT-1:0] intMask,
  input logic [PIN_COUNT-1:0] senseCfg
);
  logic anyWrite;
  logic dataWrite;
  logic dataRead;
  logic [PIN_COUNT-1:0] edgeRaw;

  assign anyWrite  = regSel && regWrEn;
  assign dataWrite = anyWrite && (regAddr[11:10] == 2'b00) && (regAddr[1:0] == 2'b00);
  assign dataRead  = regSel && !regWrEn && (regAddr[11:10] == 2'b00) && (regAddr[1:0] == 2'b00);
  assign edgeRaw   = rawStatus & ~senseCfg;

  assert_reset_clean_R1: assert property (@(posedge clk)
    !rstN |=> (pinOut == '0 && pinOutEn == '0 && !irqOut));

  assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> ((pinOut & ~$past(regAddr[9:2])) == ($past(pinOut) & ~$past(regAddr[9:2]))));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !anyWrite |=> ($stable(pinOut) && $stable(pinOutEn)));

  assert_read_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataRead |-> ((regRdData & ~regAddr[9:2]) == '0));

  assert_edge_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !anyWrite |=> ((edgeRaw & $past(edgeRaw)) == $past(edgeRaw)));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((rawStatus & intMask) != '0));
endmodule

bind gpio8_irq gpio8_irq_checker u_chk (.*);

// File: tb/test_gpio8_irq.sv
`timescale 1ns/100ps
module test_gpio8_irq;
  logic clk = 1'b0;
  logic rstN;
  logic regSel, regWrEn;
  logic [11:0] regAddr;
  logic [7:0] regWrData, regRdData, pinIn, pinOut, pinOutEn;
  logic irqOut;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio8_irq i_gpio8_irq (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    regSel = 1'b1; regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regSel = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrEn = 1'b0; regAddr = a;
    #1 d = regRdData;
    regSel = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, outModel, dirV, bit_, e0, e1, eClr, e2;
    rstN = 1'b0; regSel = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; pinIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 pinOut", pinOut, 8'h00);
    chk("R1 pinOutEn", pinOutEn, 8'h00);
    chk("R1 irqOut", {7'd0, irqOut}, 8'h00);
    rd(12'h400, d); chk("R1 dir", d, 8'h00);
    rd(12'h414, d); chk("R1 raw", d, 8'h00);

    // R4: direction register
    wr(12'h400, 8'hA5);
    rd(12'h400, d); chk("R4 dir readback", d, 8'hA5);
    chk("R4 pinOutEn", pinOutEn, 8'hA5);
    dirV = 8'hA5;

    // R2: masked data writes over every mask
    outModel = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mk, dv;
      mk = 8'(m);
      dv = 8'(m * 37 + 11);
      wr({2'b00, mk, 2'b00}, dv);
      outModel = (outModel & ~mk) | (dv & mk);
      chk("R2 masked write", pinOut, outModel);
    end

    // R3: masked data reads over every mask
    pinIn = 8'h3C;
    settle();
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mk;
      mk = 8'(m);
      rd({2'b00, mk, 2'b00}, d);
      chk("R3 masked read", d, ((dirV & outModel) | (~dirV & pinIn)) & mk);
    end

    // R11: two-stage synchronizer latency
    wr(12'h400, 8'h00);
    pinIn = 8'hC3;
    rd(12'h3FC, d); chk("R11 after one edge", d, 8'h3C);
    rd(12'h3FC, d); chk("R11 after two edges", d, 8'hC3);

    // R5 R6 R7 R8 R9: every pin in every detection mode
    for (int p = 0; p < 8; p++) begin
      for (int md = 0; md < 5; md++) begin
        bit_ = 8'(1 << p);
        wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h40C, 8'h00); wr(12'h410, 8'h00);
        pinIn = 8'h00;
        settle();
        wr(12'h404, (md >= 3) ? bit_ : 8'h00);
        wr(12'h408, (md == 2) ? bit_ : 8'h00);
        wr(12'h40C, (md == 0 || md == 3) ? bit_ : 8'h00);
        wr(12'h410, bit_);
        wr(12'h41C, 8'hFF);
        e0   = (md == 4) ? bit_ : 8'h00;
        e1   = (md == 0 || md == 2 || md == 3) ? bit_ : 8'h00;
        eClr = (md == 3) ? bit_ : 8'h00;
        e2   = (md == 1 || md == 2 || md == 4) ? bit_ : 8'h00;
        rd(12'h414, d); chk("R7 R5 initial raw", d, e0);
        pinIn = bit_;
        settle();
        rd(12'h414, d); chk("R5 R6 R7 raw after rise", d, e1);
        rd(12'h418, d); chk("R9 masked after rise", d, e1);
        chk("R9 irq after rise", {7'd0, irqOut}, {7'd0, e1 != 8'h00});
        wr(12'h41C, bit_);
        rd(12'h414, d); chk("R8 R7 raw after clear", d, eClr);
        pinIn = 8'h00;
        settle();
        rd(12'h414, d); chk("R5 R6 R7 raw after fall", d, e2);
        chk("R9 irq after fall", {7'd0, irqOut}, {7'd0, e2 != 8'h00});
      end
    end

    // R9: disabled pin raises nothing though raw is set
    wr(12'h404, 8'h01); wr(12'h408, 8'h00); wr(12'h40C, 8'h00); wr(12'h410, 8'h00);
    rd(12'h414, d); chk("R9 raw low level", d, 8'h01);
    rd(12'h418, d); chk("R9 masked zero", d, 8'h00);
    chk("R9 irq masked off", {7'd0, irqOut}, 8'h00);

    // R8: writing 0 to clear has no effect; same-cycle edge beats clear
    wr(12'h404, 8'h00); wr(12'h40C, 8'h01); wr(12'h410, 8'h01);
    pinIn = 8'h01; settle();
    wr(12'h41C, 8'h00);
    rd(12'h414, d); chk("R8 zero clear ignored", d, 8'h01);
    pinIn = 8'h00; settle();
    pinIn = 8'h01;
    @(negedge clk); @(negedge clk);
    wr(12'h41C, 8'h01);
    rd(12'h414, d); chk("R8 edge beats clear", d, 8'h01);
    wr(12'h41C, 8'h01);
    rd(12'h414, d); chk("R8 later clear works", d, 8'h00);

    // R10: mode register is plain storage
    d = pinOut;
    wr(12'h420, 8'h5A);
    rd(12'h420, e0); chk("R10 mode readback", e0, 8'h5A);
    chk("R10 pinOut unchanged", pinOut, d);
    rd(12'h414, e0); chk("R10 raw unchanged", e0, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule